// File: doc/BRIEF.md
# Exception Selector with Vector Address Output

This block decides which exception a small 8-bit CPU core takes next and gives the 16-bit address of that exception's two-byte vector. It watches fourteen hardware interrupt lines, each with its own enable, one software interrupt line driven by the instruction decoder, and six reset causes. The CPU core supplies the global interrupt mask bit, a strobe marking the last cycle of each instruction, and a mode input that selects between user and monitor operation.

A reset cause does not wait for an instruction boundary and is never masked. It wins over any interrupt, and every cause uses the same vector, whose location depends on the mode. Interrupt requests go through a sampling register. Only requests seen in the cycle before the last-cycle strobe take part in the choice at that boundary. Among the qualifying sources, the one with the higher vector address wins. Reset causes are also collected into a cause register that software reads and clears with a write strobe.

All outputs are registered, so a decision made at a clock edge appears on the outputs one cycle later as a single-cycle `take` pulse.

Top module: `exc_vector_arb`

## Requirements
- R1: If any bit of `rst_src` is high in a cycle, then in the next cycle `take` and `take_is_reset` are both 1. This holds whatever the values of `instr_last`, `i_mask`, the enables and the pending interrupts.
- R2: The reset vector address is 0xFFFE when `monitor_mode` was 0 in the cycle the reset was seen, and 0xFEFE when it was 1.
- R3: Hardware source i (bit i of `irq_req`, i = 0..13) has vector address 0xFFE0 + 2*i, so bit 0 maps to 0xFFE0 and bit 13 to 0xFFFA. The software interrupt has vector address 0xFFFC.
- R4: When several sources qualify at the same time, the one with the highest vector address wins. The software interrupt ranks above every hardware source.
- R5: An interrupt is taken only in the cycle after a cycle with `instr_last` = 1. It is taken only if its request was high in the cycle before that `instr_last` cycle. A request that first rises during the `instr_last` cycle waits for the next boundary.
- R6: While `i_mask` = 1, no hardware source is taken. A hardware source whose `irq_en` bit is 0 is never taken. The software interrupt is not blocked by `i_mask`.
- R7: `take` lasts exactly one cycle per decision and stays 0 at a boundary where nothing qualifies. `take_is_reset` is 0 for an interrupt.
- R8: The bits of `rst_cause` are: 0 power-on, 1 external pin, 2 watchdog, 3 low voltage, 4 illegal address, 5 illegal opcode. A non-power-on cause sets its bit in the next cycle, and bits already set stay set.
- R9: A power-on cause leaves only bit 0 of `rst_cause` set and clears every other bit.
- R10: A pulse on `cause_clr` clears `rst_cause` in the next cycle. If a reset cause is present in the same cycle, that cause is recorded instead.
- R11: While `rst_n` is low, `take`, `take_is_reset`, `vec_addr` and `rst_cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| rst_src | input | 6 | Reset cause lines, bit order as in R8 |
| irq_req | input | 14 | Hardware interrupt requests, bit i at vector 0xFFE0 + 2*i |
| irq_en | input | 14 | Enable for each hardware source |
| swi_req | input | 1 | Software interrupt request from the decoder |
| i_mask | input | 1 | Global interrupt mask bit |
| instr_last | input | 1 | High in the last cycle of an instruction |
| monitor_mode | input | 1 | 1 selects the monitor reset vector |
| cause_clr | input | 1 | Write strobe that clears the cause register |
| take | output | 1 | One-cycle pulse: take the exception now |
| take_is_reset | output | 1 | 1 when the exception taken is a reset |
| vec_addr | output | 16 | Address of the vector pair; holds its value between takes |
| rst_cause | output | 6 | Latched reset causes |

## Verification
The bench builds the block with its default parameters: fourteen hardware sources, a vector base of 0xFFE0 and the two reset vector addresses. With these values the lowest source (0xFFE0), the highest hardware source (0xFFFA) and the software interrupt at 0xFFFC can all be reached. This covers both ends of the priority scan and every vector R3 names. The default six-bit cause width lets the bench test power-on exclusivity, accumulation of the other causes, and the clear strobe racing a cause in the same cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_CAUSE = 6;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_PIN = 1;
  localparam int CAUSE_WDOG = 2;
  localparam int CAUSE_LVD = 3;
  localparam int CAUSE_BADADDR = 4;
  localparam int CAUSE_BADOP = 5;
  localparam logic [15:0] VEC_BASE_DEF = 16'hFFE0;
  localparam logic [15:0] RST_VEC_USER_DEF = 16'hFFFE;
  localparam logic [15:0] RST_VEC_MON_DEF = 16'hFEFE;
endpackage

// File: rtl/exc_req_sample.sv
module exc_req_sample #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] req_q_o
);
  logic [W-1:0] req_d, req_q;

  always_comb begin
    req_d = req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign req_q_o = req_q;
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int          N_HW     = 14,
  parameter logic [15:0] VEC_BASE = 16'hFFE0
) (
  input  logic [N_HW-1:0] hw_req_q,
  input  logic [N_HW-1:0] hw_en,
  input  logic            swi_q,
  input  logic            i_mask,
  output logic            hit_o,
  output logic [15:0]     vec_o
);
  localparam int NSRC = N_HW + 1;
  localparam int IDXW = $clog2(NSRC);

  logic [NSRC-1:0] qual;
  logic [IDXW-1:0] idx;

  for (genvar g = 0; g < N_HW; g++) begin : g_qual
    assign qual[g] = hw_req_q[g] & hw_en[g] & ~i_mask;
  end
  assign qual[N_HW] = swi_q;

  always_comb begin
    hit_o = 1'b0;
    idx   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (qual[i]) begin
        hit_o = 1'b1;
        idx   = IDXW'(i);
      end
    end
    vec_o = VEC_BASE + 16'({idx, 1'b0});
  end
endmodule

// File: rtl/exc_rst_cause.sv
module exc_rst_cause
  import exc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] src_i,
  input  logic                 clr_i,
  output logic [NUM_CAUSE-1:0] cause_o
);
  logic [NUM_CAUSE-1:0] cause_d, cause_q;
  logic                 cause_en;

  always_comb begin
    cause_en = (|src_i) | clr_i;
    cause_d  = cause_q;
    if (src_i[CAUSE_POR]) begin
      cause_d = NUM_CAUSE'(1) << CAUSE_POR;
    end else if (|src_i) begin
      cause_d = cause_q | src_i;
    end else if (clr_i) begin
      cause_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  assert_por_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    src_i[CAUSE_POR] |=> (cause_o == (NUM_CAUSE'(1) << CAUSE_POR)));

  assert_cause_accum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|src_i) && !src_i[CAUSE_POR]) |=>
      ((cause_o & $past(src_i)) == $past(src_i)) &&
      ((cause_o & $past(cause_o)) == $past(cause_o)));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(|src_i)) |=> (cause_o == '0));
endmodule

// File: rtl/exc_vector_arb.sv
module exc_vector_arb
  import exc_pkg::*;
#(
  parameter int          N_HW         = 14,
  parameter logic [15:0] VEC_BASE     = VEC_BASE_DEF,
  parameter logic [15:0] RST_VEC_USER = RST_VEC_USER_DEF,
  parameter logic [15:0] RST_VEC_MON  = RST_VEC_MON_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] rst_src,
  input  logic [N_HW-1:0]      irq_req,
  input  logic [N_HW-1:0]      irq_en,
  input  logic                 swi_req,
  input  logic                 i_mask,
  input  logic                 instr_last,
  input  logic                 monitor_mode,
  input  logic                 cause_clr,
  output logic                 take,
  output logic                 take_is_reset,
  output logic [15:0]          vec_addr,
  output logic [NUM_CAUSE-1:0] rst_cause
);
  localparam int NSRC = N_HW + 1;
  localparam logic [15:0] SWI_VEC = VEC_BASE + 16'(2 * N_HW);

  logic [NSRC-1:0] req_q;
  logic            pick_hit;
  logic [15:0]     pick_vec;
  logic            any_rst;

  logic        take_d, take_q;
  logic        isr_d, isr_q;
  logic [15:0] vec_d, vec_q;

  exc_req_sample #(.W(NSRC)) u_sample (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   ({swi_req, irq_req}),
    .req_q_o (req_q)
  );

  exc_prio_pick #(.N_HW(N_HW), .VEC_BASE(VEC_BASE)) u_pick (
    .hw_req_q (req_q[N_HW-1:0]),
    .hw_en    (irq_en),
    .swi_q    (req_q[N_HW]),
    .i_mask   (i_mask),
    .hit_o    (pick_hit),
    .vec_o    (pick_vec)
  );

  exc_rst_cause u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (rst_src),
    .clr_i   (cause_clr),
    .cause_o (rst_cause)
  );

  assign any_rst = |rst_src;

  always_comb begin
    take_d = 1'b0;
    isr_d  = 1'b0;
    vec_d  = vec_q;
    if (any_rst) begin
      take_d = 1'b1;
      isr_d  = 1'b1;
      vec_d  = monitor_mode ? RST_VEC_MON : RST_VEC_USER;
    end else if (instr_last && pick_hit) begin
      take_d = 1'b1;
      vec_d  = pick_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      isr_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= take_d;
      isr_q  <= isr_d;
      if (take_d) vec_q <= vec_d;
    end
  end

  assign take          = take_q;
  assign take_is_reset = isr_q;
  assign vec_addr      = vec_q;

  assert_rst_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_src) |=> (take && take_is_reset));

  assert_rst_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_src) |=> (vec_addr == ($past(monitor_mode) ? RST_VEC_MON : RST_VEC_USER)));

  assert_irq_vec_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_is_reset) |-> (vec_addr[0] == 1'b0) && (vec_addr >= VEC_BASE) &&
                                 (vec_addr <= SWI_VEC));

  assert_irq_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_is_reset) |-> $past(instr_last));

  assert_mask_swi_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_is_reset && $past(i_mask)) |-> (vec_addr == SWI_VEC));

  assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> $stable(vec_addr));
endmodule

// File: tb/sim_exc_vector_arb.sv
module sim_exc_vector_arb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  rst_src;
  logic [13:0] irq_req, irq_en;
  logic        swi_req, i_mask, instr_last, monitor_mode, cause_clr;
  logic        take, take_is_reset;
  logic [15:0] vec_addr;
  logic [5:0]  rst_cause;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  exc_vector_arb u0 (
    .clk(clk), .rst_n(rst_n), .rst_src(rst_src), .irq_req(irq_req),
    .irq_en(irq_en), .swi_req(swi_req), .i_mask(i_mask),
    .instr_last(instr_last), .monitor_mode(monitor_mode),
    .cause_clr(cause_clr), .take(take), .take_is_reset(take_is_reset),
    .vec_addr(vec_addr), .rst_cause(rst_cause)
  );

  typedef struct packed {
    logic [13:0] req;
    logic [13:0] en;
    logic        mask;
    logic        swi;
    logic        tk;
    logic [15:0] vec;
  } row_t;

  localparam int NROW = 9;
  localparam row_t TBL [NROW] = '{
    '{14'h0001, 14'h3FFF, 1'b0, 1'b0, 1'b1, 16'hFFE0},
    '{14'h2001, 14'h3FFF, 1'b0, 1'b0, 1'b1, 16'hFFFA},
    '{14'h0060, 14'h3FFF, 1'b0, 1'b0, 1'b1, 16'hFFEC},
    '{14'h2004, 14'h1FFF, 1'b0, 1'b0, 1'b1, 16'hFFE4},
    '{14'h3FFF, 14'h3FFF, 1'b1, 1'b0, 1'b0, 16'h0000},
    '{14'h3FFF, 14'h3FFF, 1'b1, 1'b1, 1'b1, 16'hFFFC},
    '{14'h2000, 14'h3FFF, 1'b0, 1'b1, 1'b1, 16'hFFFC},
    '{14'h3FFF, 14'h0000, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{14'h0400, 14'h3FFF, 1'b0, 1'b0, 1'b1, 16'hFFF4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rst_src = '0; irq_req = '0; irq_en = '0; swi_req = 1'b0;
    i_mask = 1'b0; instr_last = 1'b0; monitor_mode = 1'b0; cause_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 take", 32'(take), 32'd0);
    chk("R11 take_is_reset", 32'(take_is_reset), 32'd0);
    chk("R11 vec_addr", 32'(vec_addr), 32'd0);
    chk("R11 rst_cause", 32'(rst_cause), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R3 R4 R5 R6 R7
    for (int k = 0; k < NROW; k++) begin
      irq_req = TBL[k].req; irq_en = TBL[k].en; i_mask = TBL[k].mask;
      swi_req = TBL[k].swi; instr_last = 1'b0;
      @(negedge clk);
      instr_last = 1'b1;
      @(negedge clk);
      instr_last = 1'b0;
      chk($sformatf("R4 R6 row%0d take", k), 32'(take), 32'(TBL[k].tk));
      if (TBL[k].tk) chk($sformatf("R3 R4 row%0d vec", k), 32'(vec_addr), 32'(TBL[k].vec));
      chk($sformatf("R7 row%0d is_reset", k), 32'(take_is_reset), 32'd0);
      irq_req = '0; swi_req = 1'b0; i_mask = 1'b0;
      @(negedge clk);
      chk($sformatf("R7 row%0d single pulse", k), 32'(take), 32'd0);
    end

    // R5: request rising in the last cycle waits one instruction
    irq_en = 14'h3FFF;
    irq_req = 14'h0008; instr_last = 1'b1;
    @(negedge clk);
    instr_last = 1'b0;
    chk("R5 late request not taken", 32'(take), 32'd0);
    @(negedge clk);
    instr_last = 1'b1;
    @(negedge clk);
    instr_last = 1'b0;
    chk("R5 taken next boundary", 32'(take), 32'd1);
    chk("R5 next boundary vec", 32'(vec_addr), 32'h0000FFE6);
    irq_req = '0;
    @(negedge clk);

    // R1 R2 R8: pin reset in user mode, no boundary
    rst_src = 6'b000010;
    @(negedge clk);
    rst_src = '0;
    chk("R1 pin take", 32'({take, take_is_reset}), 32'b11);
    chk("R2 user vec", 32'(vec_addr), 32'h0000FFFE);
    chk("R8 pin cause", 32'(rst_cause), 32'h02);
    @(negedge clk);

    // R1 R2 R8: watchdog in monitor mode with mask set
    rst_src = 6'b000100; monitor_mode = 1'b1; i_mask = 1'b1;
    @(negedge clk);
    rst_src = '0; monitor_mode = 1'b0; i_mask = 1'b0;
    chk("R1 unmaskable take", 32'({take, take_is_reset}), 32'b11);
    chk("R2 monitor vec", 32'(vec_addr), 32'h0000FEFE);
    chk("R8 accumulate", 32'(rst_cause), 32'h06);
    @(negedge clk);

    // R1: reset beats pending interrupt at a boundary
    irq_req = 14'h2000;
    @(negedge clk);
    instr_last = 1'b1; rst_src = 6'b100000;
    @(negedge clk);
    instr_last = 1'b0; rst_src = '0; irq_req = '0;
    chk("R1 reset wins is_reset", 32'(take_is_reset), 32'd1);
    chk("R1 reset wins vec", 32'(vec_addr), 32'h0000FFFE);
    chk("R8 opcode cause", 32'(rst_cause), 32'h26);
    @(negedge clk);

    // R9: power-on with another cause
    rst_src = 6'b010001;
    @(negedge clk);
    rst_src = '0;
    chk("R9 power-on only", 32'(rst_cause), 32'h01);
    @(negedge clk);

    // R10: clear
    cause_clr = 1'b1;
    @(negedge clk);
    cause_clr = 1'b0;
    chk("R10 cleared", 32'(rst_cause), 32'h00);
    chk("R7 no take idle", 32'(take), 32'd0);

    // R10: clear racing a cause
    cause_clr = 1'b1; rst_src = 6'b001000;
    @(negedge clk);
    cause_clr = 1'b0; rst_src = '0;
    chk("R10 cause beats clear", 32'(rst_cause), 32'h08);
    @(negedge clk);
    chk("R7 vec holds", 32'(vec_addr), 32'h0000FFFE);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule